// File: doc/BRIEF.md
# SPI Byte Master with Status Flags

This block is a serial-peripheral master that moves one byte at a time over a three-wire link (SCK, MOSI, MISO). A processor drives it through a small read/write bus with three registers: control, status and data. Writing the data register while the block is enabled and in master mode starts an exchange. Eight SCK cycles later the received byte is readable at the same address, and a completion flag is raised in the status register.

The SCK frequency is the system clock divided by a factor picked from a fixed table. Two rate bits in the control register and a speed-doubling bit in the status register select the entry. The completion flag and a write-collision flag clear in one of two ways: the CPU reads the status register and sees the flag set, then touches the data register. The completion flag also clears on an interrupt acknowledge. An interrupt request follows the completion flag, gated by a local enable and a global enable.

When the slave-select pin is configured as an input and is pulled low while the block is master, the block treats this as another master taking the bus. It drops out of master mode, aborts the byte in flight and raises the completion flag.

Top module: `spi_byte_master`

## Requirements
- R1: The register map is: address 0 control, address 1 status, address 2 data, address 3 reads zero. Control bit 7 is interrupt enable, bit 6 is block enable, bit 4 is master select and bits 1:0 are the rate code. After reset, control, status and data all read 0, SCK and MOSI are low, and the interrupt request is low.
- R2: With the doubling bit at 0, rate codes 0, 1, 2 and 3 give an SCK period of 4, 16, 64 and 128 system clocks. One byte takes 8 SCK periods.
- R3: With the doubling bit at 1, rate codes 0, 1, 2 and 3 give an SCK period of 2, 8, 32 and 64 system clocks.
- R4: SCK idles low. MOSI carries the byte most significant bit first and is valid from the start of the transfer. MOSI changes only after a falling SCK edge, and MISO is sampled on each rising edge. After completion the received byte reads at the data address.
- R5: Status bit 7 (completion) becomes set exactly 8×period system clocks after the clock edge that accepts the data write, and not one cycle earlier.
- R6: A data write while a transfer is in progress sets status bit 6 (collision). The written byte is discarded and the transfer in flight goes on unchanged.
- R7: A data-register access (read or write) clears only those of bits 7 and 6 that an earlier status read saw set since the previous data access. A flag not seen set survives the access.
- R8: The interrupt request is high exactly while status bit 7, control bit 7 and the global-enable input are all high. A one-cycle acknowledge pulse clears status bit 7.
- R9: In master mode, with the slave-select pin configured as input, a low level on it clears control bit 4, stops the transfer with SCK low, and sets status bit 7. The same low level has no effect when the pin is configured as output.
- R10: Status bits 5 to 1 always read 0. Bits 7 and 6 cannot be written. Bit 0 is the read/write doubling bit. Control bits 5, 3 and 2 always read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_sel | input | 1 | Bus access strobe for this cycle |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 2 | Register address |
| bus_wdata | input | DATA_W | Write data |
| bus_rdata | output | DATA_W | Read data for bus_addr (combinational) |
| glob_ie | input | 1 | Global interrupt enable |
| irq_ack | input | 1 | Interrupt acknowledge pulse |
| irq | output | 1 | Interrupt request |
| sck | output | 1 | Serial clock |
| mosi | output | 1 | Serial data out |
| miso | input | 1 | Serial data in |
| ss_is_input | input | 1 | 1 when the slave-select pin is configured as input |
| ss_n | input | 1 | Level on the slave-select pin (active low) |

## Verification
Register writes take effect at the clock edge that accepts them. Reads are combinational from the address, so the bench can look at any register by setting the address with the strobe low, and such a look has no side effects. The completion flag is due 8×period edges after the data-write edge. The bench counts falling clock edges from that write and samples the status once after edge 8×period−1, where it expects 0, and once after edge 8×period, where it expects 1. The interrupt output is combinational from the flag and the two enables, and is checked a moment after each input change. The slave-select fault is checked on the falling edge that follows the single cycle in which the pin is held low.

// File: rtl/spi_bm_pkg.sv
package spi_bm_pkg;

    localparam logic [1:0] ADDR_CTRL = 2'd0;
    localparam logic [1:0] ADDR_STAT = 2'd1;
    localparam logic [1:0] ADDR_DATA = 2'd2;

    localparam int CB_IE  = 7;
    localparam int CB_EN  = 6;
    localparam int CB_MST = 4;

    localparam logic [7:0] CTRL_MASK = 8'hD3;

    typedef struct packed {
        logic [7:0] ctrl;
        logic       dbl;
    } cfg_t;

endpackage

// File: rtl/sm_rate_sel.sv
module sm_rate_sel #(
    parameter int HALF_W = 7
) (
    input  logic [1:0]        rate,
    input  logic              dbl,
    output logic [HALF_W-1:0] half
);
    localparam int BW = HALF_W + 1;

    logic [BW-1:0] base;

    // base is the half period (in system clocks) at normal speed
    always_comb begin
        case (rate)
            2'd0:    base = BW'(2);
            2'd1:    base = BW'(8);
            2'd2:    base = BW'(32);
            default: base = BW'(64);
        endcase
        half = HALF_W'(base >> dbl);
    end

    always_comb begin
        a_r3_half_nonzero: assert (half != '0);
    end

endmodule

// File: rtl/sm_shifter.sv
module sm_shifter #(
    parameter int DATA_W = 8,
    parameter int HALF_W = 7
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [DATA_W-1:0] load_byte,
    input  logic              abort,
    input  logic [HALF_W-1:0] half,
    input  logic              miso,
    output logic              sck,
    output logic              mosi,
    output logic              busy,
    output logic              done,
    output logic [DATA_W-1:0] rx_byte
);
    localparam int PH_W = $clog2(2 * DATA_W);
    localparam logic [PH_W-1:0] PH_LAST = PH_W'(2 * DATA_W - 1);

    typedef struct packed {
        logic              busy;
        logic              sck;
        logic              smp;
        logic [HALF_W-1:0] div;
        logic [HALF_W-1:0] hlf;
        logic [PH_W-1:0]   ph;
        logic [DATA_W-1:0] sh;
    } sh_t;

    sh_t q, d;

    always_comb begin
        d    = q;
        done = 1'b0;
        if (abort) begin
            d.busy = 1'b0;
            d.sck  = 1'b0;
            d.div  = '0;
            d.ph   = '0;
        end else if (!q.busy) begin
            if (start) begin
                d.busy = 1'b1;
                d.sck  = 1'b0;
                d.div  = '0;
                d.ph   = '0;
                d.sh   = load_byte;
                d.hlf  = half;
            end
        end else if (q.div == q.hlf - 1'b1) begin
            d.div = '0;
            d.ph  = q.ph + 1'b1;
            if (!q.sck) begin
                d.sck = 1'b1;
                d.smp = miso;
            end else begin
                d.sck = 1'b0;
                d.sh  = {q.sh[DATA_W-2:0], q.smp};
                if (q.ph == PH_LAST) begin
                    d.busy = 1'b0;
                    done   = 1'b1;
                end
            end
        end else begin
            d.div = q.div + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign sck     = q.sck;
    assign mosi    = q.sh[DATA_W-1];
    assign busy    = q.busy;
    assign rx_byte = q.sh;

    // R4: clock idles low outside a transfer
    a_r4_sck_idle_low: assert property (@(posedge clk) disable iff (!rst_n)
        !q.busy |-> !q.sck);
    // R4: MOSI does not move while SCK is high
    a_r4_mosi_hold: assert property (@(posedge clk) disable iff (!rst_n)
        q.sck |-> $stable(mosi));
    // R2: divider count stays inside the latched half period
    a_r2_div_bound: assert property (@(posedge clk) disable iff (!rst_n)
        q.busy |-> (q.div < q.hlf));

endmodule

// File: rtl/sm_flags.sv
module sm_flags (
    input  logic clk,
    input  logic rst_n,
    input  logic stat_rd,
    input  logic data_acc,
    input  logic done_set,
    input  logic fault_set,
    input  logic coll_set,
    input  logic irq_ack,
    output logic done_flag,
    output logic coll_flag
);
    typedef struct packed {
        logic spif;
        logic wcol;
        logic arm_s;
        logic arm_w;
    } fl_t;

    fl_t q, d;

    always_comb begin
        d = q;
        if (stat_rd) begin
            d.arm_s = q.arm_s | q.spif;
            d.arm_w = q.arm_w | q.wcol;
        end
        if (data_acc) begin
            if (q.arm_s) d.spif = 1'b0;
            if (q.arm_w) d.wcol = 1'b0;
            d.arm_s = 1'b0;
            d.arm_w = 1'b0;
        end
        if (irq_ack)               d.spif = 1'b0;
        if (done_set || fault_set) d.spif = 1'b1;
        if (coll_set)              d.wcol = 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign done_flag = q.spif;
    assign coll_flag = q.wcol;

    // R5: completion pulse from the shifter raises the flag
    a_r5_done_sets: assert property (@(posedge clk) disable iff (!rst_n)
        done_set |=> done_flag);
    // R6: a colliding write raises the collision flag
    a_r6_coll_sets: assert property (@(posedge clk) disable iff (!rst_n)
        coll_set |=> coll_flag);
    // R7: an unseen completion flag survives a data access
    a_r7_unseen_kept: assert property (@(posedge clk) disable iff (!rst_n)
        (data_acc && q.spif && !q.arm_s && !irq_ack) |=> done_flag);
    // R8: acknowledge clears the completion flag
    a_r8_ack_clears: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_ack && !done_set && !fault_set) |=> !done_flag);

endmodule

// File: rtl/spi_byte_master.sv
module spi_byte_master #(
    parameter int DATA_W = 8,
    parameter int HALF_W = 7
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_sel,
    input  logic              bus_we,
    input  logic [1:0]        bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    input  logic              glob_ie,
    input  logic              irq_ack,
    output logic              irq,
    output logic              sck,
    output logic              mosi,
    input  logic              miso,
    input  logic              ss_is_input,
    input  logic              ss_n
);
    import spi_bm_pkg::*;

    cfg_t q, d;

    logic              wr_ctrl, wr_stat, wr_data, rd_stat, data_acc;
    logic              fault, start, coll;
    logic              busy, done, done_flag, coll_flag;
    logic [HALF_W-1:0] half;
    logic [DATA_W-1:0] rx_byte;

    assign wr_ctrl  = bus_sel && bus_we && (bus_addr == ADDR_CTRL);
    assign wr_stat  = bus_sel && bus_we && (bus_addr == ADDR_STAT);
    assign wr_data  = bus_sel && bus_we && (bus_addr == ADDR_DATA);
    assign rd_stat  = bus_sel && !bus_we && (bus_addr == ADDR_STAT);
    assign data_acc = bus_sel && (bus_addr == ADDR_DATA);

    assign fault = q.ctrl[CB_MST] && ss_is_input && !ss_n;
    assign start = wr_data && q.ctrl[CB_EN] && q.ctrl[CB_MST] && !busy && !fault;
    assign coll  = wr_data && busy;

    always_comb begin
        d = q;
        if (wr_ctrl) d.ctrl = bus_wdata[7:0] & CTRL_MASK;
        if (wr_stat) d.dbl  = bus_wdata[0];
        if (fault)   d.ctrl[CB_MST] = 1'b0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    sm_rate_sel #(.HALF_W(HALF_W)) u_rate (
        .rate (q.ctrl[1:0]),
        .dbl  (q.dbl),
        .half (half)
    );

    sm_shifter #(.DATA_W(DATA_W), .HALF_W(HALF_W)) u_shift (
        .clk       (clk),
        .rst_n     (rst_n),
        .start     (start),
        .load_byte (bus_wdata),
        .abort     (fault),
        .half      (half),
        .miso      (miso),
        .sck       (sck),
        .mosi      (mosi),
        .busy      (busy),
        .done      (done),
        .rx_byte   (rx_byte)
    );

    sm_flags u_flags (
        .clk       (clk),
        .rst_n     (rst_n),
        .stat_rd   (rd_stat),
        .data_acc  (data_acc),
        .done_set  (done),
        .fault_set (fault),
        .coll_set  (coll),
        .irq_ack   (irq_ack),
        .done_flag (done_flag),
        .coll_flag (coll_flag)
    );

    always_comb begin
        case (bus_addr)
            ADDR_CTRL: bus_rdata = DATA_W'(q.ctrl);
            ADDR_STAT: bus_rdata = DATA_W'({done_flag, coll_flag, 5'b0, q.dbl});
            ADDR_DATA: bus_rdata = rx_byte;
            default:   bus_rdata = '0;
        endcase
    end

    assign irq = done_flag && q.ctrl[CB_IE] && glob_ie;

    // R9: a slave-select fault leaves master mode and stops the shifter
    a_r9_fault_exit: assert property (@(posedge clk) disable iff (!rst_n)
        fault |=> (!q.ctrl[CB_MST] && !busy && !sck && done_flag));
    // R6: a colliding write does not disturb the running transfer
    a_r6_coll_keeps_busy: assert property (@(posedge clk) disable iff (!rst_n)
        (coll && !done && !fault) |=> busy);

endmodule

// File: tb/sim_spi_byte_master.sv
module sim_spi_byte_master;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       bus_sel = 1'b0, bus_we = 1'b0;
    logic [1:0] bus_addr = 2'd0;
    logic [7:0] bus_wdata = 8'h00;
    logic [7:0] bus_rdata;
    logic       glob_ie = 1'b0, irq_ack = 1'b0, irq;
    logic       sck, mosi, miso;
    logic       ss_is_input = 1'b0, ss_n = 1'b1;

    int total = 0, bad = 0;

    always #10 clk = ~clk;

    spi_byte_master u0 (
        .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_we(bus_we),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .glob_ie(glob_ie), .irq_ack(irq_ack), .irq(irq), .sck(sck),
        .mosi(mosi), .miso(miso), .ss_is_input(ss_is_input), .ss_n(ss_n)
    );

    // slave model
    int         fall_cnt = 0, rise_cnt = 0, s_base = 0;
    logic [7:0] s_pat = 8'h00, s_rx = 8'h00;
    always @(negedge sck) fall_cnt <= fall_cnt + 1;
    always @(posedge sck) begin
        rise_cnt <= rise_cnt + 1;
        s_rx     <= {s_rx[6:0], mosi};
    end
    assign miso = s_pat[3'(7 - (fall_cnt - s_base))];

    task automatic chk(input string req, input int act, input int exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic bus_wr(input logic [1:0] a, input logic [7:0] v);
        @(negedge clk);
        bus_sel = 1'b1; bus_we = 1'b1; bus_addr = a; bus_wdata = v;
        @(negedge clk);
        bus_sel = 1'b0; bus_we = 1'b0;
    endtask

    task automatic bus_rd(input logic [1:0] a, output logic [7:0] v);
        @(negedge clk);
        bus_sel = 1'b1; bus_we = 1'b0; bus_addr = a;
        #1 v = bus_rdata;
        @(negedge clk);
        bus_sel = 1'b0;
    endtask

    task automatic peek(input logic [1:0] a, output logic [7:0] v);
        bus_addr = a;
        #1 v = bus_rdata;
    endtask

    task automatic wait_flag(input int max);
        logic [7:0] v;
        for (int i = 0; i < max; i++) begin
            @(negedge clk);
            peek(2'd1, v);
            if (v[7]) break;
        end
    endtask

    function automatic int exp_div(input int rate, input int dbl);
        int b;
        b = (rate == 0) ? 4 : (rate == 1) ? 16 : (rate == 2) ? 64 : 128;
        return dbl ? b / 2 : b;
    endfunction

    task automatic xfer(input int rate, input int dbl, input logic [7:0] tx,
                        input logic [7:0] pat, input string req);
        logic [7:0] v;
        int n, r0;
        n = exp_div(rate, dbl);
        bus_wr(2'd1, 8'(dbl));
        bus_wr(2'd0, 8'h50 | 8'(rate));
        s_pat  = pat;
        s_base = fall_cnt;
        r0     = rise_cnt;
        bus_wr(2'd2, tx);
        repeat (8 * n - 1) @(negedge clk);
        peek(2'd1, v);
        chk({req, " R5 flag early"}, int'(v[7]), 0);
        @(negedge clk);
        peek(2'd1, v);
        chk({req, " R5 flag due"}, int'(v[7]), 1);
        chk("R4 sck edges", rise_cnt - r0, 8);
        chk("R4 slave got mosi byte", int'(s_rx), int'(tx));
        bus_rd(2'd1, v);
        chk("R10 status read", int'(v), int'(8'h80 | 8'(dbl)));
        bus_rd(2'd2, v);
        chk("R4 received byte", int'(v), int'(pat));
        peek(2'd1, v);
        chk("R7 cleared after sequence", int'(v), dbl);
    endtask

    task automatic finish_run;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        total++; bad++;
        $display("FAIL watchdog actual=hung expected=finished");
        finish_run();
    end

    initial begin
        logic [7:0] v;
        int r0;
        void'($urandom(32'd1107));
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset values
        peek(2'd0, v); chk("R1 ctrl reset", int'(v), 0);
        peek(2'd1, v); chk("R1 status reset", int'(v), 0);
        peek(2'd2, v); chk("R1 data reset", int'(v), 0);
        peek(2'd3, v); chk("R1 addr3 zero", int'(v), 0);
        chk("R1 sck low", int'(sck), 0);
        chk("R1 mosi low", int'(mosi), 0);
        chk("R1 irq low", int'(irq), 0);

        // R10 read-only and reserved bits
        bus_wr(2'd1, 8'hFF);
        peek(2'd1, v); chk("R10 status write mask", int'(v), 8'h01);
        bus_wr(2'd0, 8'hFF);
        peek(2'd0, v); chk("R10 ctrl write mask", int'(v), 8'hD3);
        bus_wr(2'd0, 8'h00);
        bus_wr(2'd1, 8'h00);

        // R2 / R3 every table entry
        for (int r = 0; r < 4; r++) xfer(r, 0, 8'hA5 ^ 8'(r), 8'h3C + 8'(r), "R2");
        for (int r = 0; r < 4; r++) xfer(r, 1, 8'h96 + 8'(r), 8'hC3 ^ 8'(r), "R3");

        // random traffic
        for (int k = 0; k < 12; k++)
            xfer(int'($urandom % 4), int'($urandom % 2), 8'($urandom), 8'($urandom), "R2 R3 rand");

        // R6 and R7: collision mid-transfer, partial clear
        bus_wr(2'd1, 8'h00);
        bus_wr(2'd0, 8'h52);
        s_pat = 8'h5A; s_base = fall_cnt;
        bus_wr(2'd2, 8'hE1);
        repeat (20) @(negedge clk);
        bus_wr(2'd2, 8'h1E);
        peek(2'd1, v); chk("R6 collision flag", int'(v), 8'h40);
        bus_rd(2'd1, v);
        wait_flag(1000);
        chk("R6 shift unchanged", int'(s_rx), 8'hE1);
        bus_rd(2'd2, v);
        chk("R6 rx intact", int'(v), 8'h5A);
        peek(2'd1, v); chk("R7 unseen flag kept", int'(v), 8'h80);
        bus_rd(2'd1, v);
        bus_rd(2'd2, v);
        peek(2'd1, v); chk("R7 both cleared", int'(v), 8'h00);

        // R8 interrupt gating and acknowledge
        glob_ie = 1'b1;
        bus_wr(2'd0, 8'hD0);
        s_pat = 8'h81; s_base = fall_cnt;
        bus_wr(2'd2, 8'h18);
        #1 chk("R8 irq low while busy", int'(irq), 0);
        wait_flag(100);
        chk("R8 irq high", int'(irq), 1);
        glob_ie = 1'b0;
        #1 chk("R8 global gate", int'(irq), 0);
        glob_ie = 1'b1;
        #1 chk("R8 irq again", int'(irq), 1);
        @(negedge clk); irq_ack = 1'b1;
        @(negedge clk); irq_ack = 1'b0;
        peek(2'd1, v); chk("R8 ack clears flag", int'(v[7]), 0);
        chk("R8 irq after ack", int'(irq), 0);
        bus_wr(2'd0, 8'h50);

        // R9: low select while pin is an output has no effect
        ss_n = 1'b0;
        repeat (3) @(negedge clk);
        peek(2'd0, v); chk("R9 output pin ignored", int'(v), 8'h50);
        ss_n = 1'b1;

        // R9 mode fault mid-transfer
        ss_is_input = 1'b1;
        bus_wr(2'd0, 8'h53);
        s_base = fall_cnt;
        bus_wr(2'd2, 8'h77);
        repeat (300) @(negedge clk);
        ss_n = 1'b0;
        @(negedge clk);
        ss_n = 1'b1;
        peek(2'd0, v); chk("R9 master cleared", int'(v), 8'h43);
        peek(2'd1, v); chk("R9 flag set", int'(v[7]), 1);
        chk("R9 sck low", int'(sck), 0);
        r0 = rise_cnt;
        repeat (1200) @(negedge clk);
        chk("R9 transfer stopped", rise_cnt, r0);
        bus_wr(2'd2, 8'h11);
        repeat (300) @(negedge clk);
        chk("R9 no start as non-master", rise_cnt, r0);

        finish_run();
    end
endmodule